// File: doc/BRIEF.md
# Virtual Interrupt List Register Unit

This block keeps a small bank of list registers for the virtual side of an interrupt CPU interface. The host programs each entry through a write port. An entry holds a virtual interrupt ID, a pending bit, an active bit, a hardware-link flag and a linked physical interrupt ID. The guest acknowledges interrupts through an acknowledge strobe, which returns one virtual ID. It retires interrupts through a deactivate strobe that carries a virtual ID.

A hardware-linked entry stands for a physical interrupt that is still active on the physical distributor. When the guest deactivates such an entry, the block does not retire it locally. It sends a one-cycle physical deactivate request that carries the linked physical ID, and the entry stays Active until the host clears it. A linked entry may never hold pending and active together, so a host write that asks for that combination is refused.

Top module: `virq_lr_unit`

## Requirements
- R1: After reset every entry is Inactive with its link flag clear, and `ack_vld_o`, `pdeact_o`, `wr_err_o` and `eoi_err_o` are low.
- R2: A host write loads the entry at `host_idx_i`, and the new state is visible one cycle later. In `lr_state_o`, entry i uses bits [2i+1:2i], where bit 2i is pending and bit 2i+1 is active. In `lr_hw_o`, bit i is the link flag. The state codes are 00 Inactive, 01 Pending, 10 Active and 11 Pending+Active.
- R3: A host write with the link flag set and state 11 leaves the entry unchanged. It raises `wr_err_o` for exactly the next cycle. A linked entry never holds state 11.
- R4: An acknowledge returns, one cycle later on `ack_vid_o` with `ack_vld_o` high, the virtual ID of the lowest-index entry with the pending bit set. That entry's pending bit clears and its active bit sets.
- R5: An acknowledge with no pending entry returns 1023 (all ones) and changes no entry.
- R6: A deactivate whose ID matches an active entry without the link flag clears that entry's active bit, so Active becomes Inactive and Pending+Active becomes Pending. No physical request is issued.
- R7: A deactivate that matches an active linked entry pulses `pdeact_o` for one cycle, starting the next cycle, with that entry's physical ID on `pdeact_pid_o`. The entry stays Active.
- R8: A linked entry that has already forwarded its deactivate no longer matches a deactivate. A repeated deactivate of it issues no second request.
- R9: A deactivate that matches no eligible active entry changes no entry. It sets `eoi_err_o`, which stays high until reset.
- R10: A host clear sets the entry to Inactive and clears its link flag in one cycle.
- R11: A clear and a write to the same index in the same cycle leave the entry as the clear alone would.
- R12: When several eligible active entries carry the deactivated ID, only the lowest-index one is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_idx_i | input | 2 | Entry index for the write |
| host_vid_i | input | 10 | Virtual ID to write |
| host_pid_i | input | 10 | Physical ID to write |
| host_hw_i | input | 1 | Link flag to write |
| host_state_i | input | 2 | State to write (bit0 pending, bit1 active) |
| host_clr_i | input | 1 | Host clear strobe |
| host_clr_idx_i | input | 2 | Entry index for the clear |
| ack_i | input | 1 | Guest acknowledge strobe |
| ack_vld_o | output | 1 | Acknowledge result valid |
| ack_vid_o | output | 10 | Acknowledged virtual ID or 1023 |
| eoi_i | input | 1 | Guest deactivate strobe |
| eoi_vid_i | input | 10 | Virtual ID being deactivated |
| pdeact_o | output | 1 | Physical deactivate request |
| pdeact_pid_o | output | 10 | Physical ID for the request |
| wr_err_o | output | 1 | Rejected-write pulse |
| eoi_err_o | output | 1 | Sticky unmatched-deactivate flag |
| lr_state_o | output | 8 | State of all entries |
| lr_hw_o | output | 4 | Link flag of all entries |

## Verification
The assertions assume that every acknowledge produces a response on the following cycle, and that a physical request can only come from a deactivate on the previous cycle. Neither holds if the strobes are driven while reset is low. The stimulus raises strobes only after reset is released.

The stimulus applies at most one host operation per entry per cycle, except in the deliberate clear-and-write collision. It never deactivates an entry in the same cycle that the host rewrites that entry. Under these limits the expected IDs and states follow from the requirements alone.

// File: rtl/virq_lr_pkg.sv
package virq_lr_pkg;
  localparam int unsigned ST_W = 2;
  localparam logic [ST_W-1:0] ST_IDLE = 2'b00;
  localparam logic [ST_W-1:0] ST_PEND = 2'b01;
  localparam logic [ST_W-1:0] ST_ACT  = 2'b10;
  localparam logic [ST_W-1:0] ST_PACT = 2'b11;
endpackage

// File: rtl/virq_lr_pick.sv
module virq_lr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/virq_lr_entry.sv
module virq_lr_entry #(
  parameter int unsigned ID_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [ID_W-1:0] wr_vid_i,
  input  logic [ID_W-1:0] wr_pid_i,
  input  logic            wr_hw_i,
  input  logic [1:0]      wr_state_i,
  input  logic            clr_i,
  input  logic            ack_hit_i,
  input  logic            eoi_hit_i,
  output logic [ID_W-1:0] vid_o,
  output logic [ID_W-1:0] pid_o,
  output logic            hw_o,
  output logic            pend_o,
  output logic            act_o,
  output logic            fwd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_o  <= '0;
      pid_o  <= '0;
      hw_o   <= 1'b0;
      pend_o <= 1'b0;
      act_o  <= 1'b0;
      fwd_o  <= 1'b0;
    end else if (clr_i) begin
      pend_o <= 1'b0;
      act_o  <= 1'b0;
      hw_o   <= 1'b0;
      fwd_o  <= 1'b0;
    end else if (wr_i) begin
      vid_o  <= wr_vid_i;
      pid_o  <= wr_pid_i;
      hw_o   <= wr_hw_i;
      pend_o <= wr_state_i[0];
      act_o  <= wr_state_i[1];
      fwd_o  <= 1'b0;
    end else begin
      pend_o <= pend_o & ~ack_hit_i;
      // linked entries hold Active after forwarding; only mark forwarded
      act_o  <= (act_o & ~(eoi_hit_i & ~hw_o)) | ack_hit_i;
      if (eoi_hit_i && hw_o) fwd_o <= 1'b1;
    end
  end
endmodule

// File: rtl/virq_lr_unit.sv
module virq_lr_unit
  import virq_lr_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  parameter int unsigned ID_W   = 10,
  localparam int unsigned IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 host_wr_i,
  input  logic [IDX_W-1:0]     host_idx_i,
  input  logic [ID_W-1:0]      host_vid_i,
  input  logic [ID_W-1:0]      host_pid_i,
  input  logic                 host_hw_i,
  input  logic [ST_W-1:0]      host_state_i,
  input  logic                 host_clr_i,
  input  logic [IDX_W-1:0]     host_clr_idx_i,
  input  logic                 ack_i,
  output logic                 ack_vld_o,
  output logic [ID_W-1:0]      ack_vid_o,
  input  logic                 eoi_i,
  input  logic [ID_W-1:0]      eoi_vid_i,
  output logic                 pdeact_o,
  output logic [ID_W-1:0]      pdeact_pid_o,
  output logic                 wr_err_o,
  output logic                 eoi_err_o,
  output logic [NUM_LR*ST_W-1:0] lr_state_o,
  output logic [NUM_LR-1:0]    lr_hw_o
);
  localparam logic [ID_W-1:0] SPURIOUS = '1;

  logic [ID_W-1:0]  vid [NUM_LR];
  logic [ID_W-1:0]  pid [NUM_LR];
  logic [NUM_LR-1:0] hw, pend, act, fwd;
  logic [NUM_LR-1:0] ack_hit, eoi_hit, eoi_match;
  logic [IDX_W-1:0] ack_idx, eoi_idx;
  logic             ack_any, eoi_any;
  logic             wr_bad, wr_ok;

  assign wr_bad = host_wr_i & host_hw_i & (host_state_i == ST_PACT);
  assign wr_ok  = host_wr_i & ~wr_bad;

  virq_lr_pick #(.N(NUM_LR), .IW(IDX_W)) u_ack_pick (
    .req_i(pend), .idx_o(ack_idx), .any_o(ack_any)
  );

  virq_lr_pick #(.N(NUM_LR), .IW(IDX_W)) u_eoi_pick (
    .req_i(eoi_match), .idx_o(eoi_idx), .any_o(eoi_any)
  );

  for (genvar g = 0; g < NUM_LR; g++) begin : g_lr
    assign eoi_match[g] = act[g] & ~fwd[g] & (vid[g] == eoi_vid_i);
    assign ack_hit[g]   = ack_i & ack_any & (ack_idx == IDX_W'(g));
    assign eoi_hit[g]   = eoi_i & eoi_any & (eoi_idx == IDX_W'(g));

    virq_lr_entry #(.ID_W(ID_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_ok && host_idx_i == IDX_W'(g)),
      .wr_vid_i   (host_vid_i),
      .wr_pid_i   (host_pid_i),
      .wr_hw_i    (host_hw_i),
      .wr_state_i (host_state_i),
      .clr_i      (host_clr_i && host_clr_idx_i == IDX_W'(g)),
      .ack_hit_i  (ack_hit[g]),
      .eoi_hit_i  (eoi_hit[g]),
      .vid_o      (vid[g]),
      .pid_o      (pid[g]),
      .hw_o       (hw[g]),
      .pend_o     (pend[g]),
      .act_o      (act[g]),
      .fwd_o      (fwd[g])
    );

    assign lr_state_o[g*ST_W +: ST_W] = {act[g], pend[g]};
  end

  assign lr_hw_o = hw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_o    <= 1'b0;
      ack_vid_o    <= '0;
      pdeact_o     <= 1'b0;
      pdeact_pid_o <= '0;
      wr_err_o     <= 1'b0;
      eoi_err_o    <= 1'b0;
    end else begin
      ack_vld_o <= ack_i;
      if (ack_i) ack_vid_o <= ack_any ? vid[ack_idx] : SPURIOUS;
      pdeact_o  <= eoi_i & eoi_any & hw[eoi_idx];
      if (eoi_i && eoi_any && hw[eoi_idx]) pdeact_pid_o <= pid[eoi_idx];
      wr_err_o  <= wr_bad;
      eoi_err_o <= eoi_err_o | (eoi_i & ~eoi_any);
    end
  end
endmodule

// File: rtl/virq_lr_chk.sv
module virq_lr_chk #(
  parameter int unsigned NUM_LR = 4,
  parameter int unsigned ID_W   = 10,
  localparam int unsigned IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   host_wr_i,
  input logic [IDX_W-1:0]       host_idx_i,
  input logic                   host_hw_i,
  input logic [1:0]             host_state_i,
  input logic                   host_clr_i,
  input logic                   ack_i,
  input logic                   ack_vld_o,
  input logic                   eoi_i,
  input logic                   pdeact_o,
  input logic                   wr_err_o,
  input logic                   eoi_err_o,
  input logic [NUM_LR*2-1:0]    lr_state_o,
  input logic [NUM_LR-1:0]      lr_hw_o
);
  a_r4_ack_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ack_vld_o);

  a_r4_resp_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> $past(ack_i));

  a_r7_pdeact_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdeact_o |-> $past(eoi_i));

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_err_o |=> eoi_err_o);

  a_r3_bad_write_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_hw_i && host_state_i == 2'b11) |=> wr_err_o);

  a_r3_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(host_wr_i && host_hw_i));

  for (genvar g = 0; g < NUM_LR; g++) begin : g_chk
    a_r3_hw_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lr_hw_o[g] |-> (lr_state_o[2*g +: 2] != 2'b11));
  end
endmodule

bind virq_lr_unit virq_lr_chk #(.NUM_LR(NUM_LR), .ID_W(ID_W)) u_chk (.*);

// File: tb/tb_virq_lr_unit.sv
module tb_virq_lr_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_wr_i = 0, host_hw_i = 0, host_clr_i = 0;
  logic [1:0] host_idx_i = 0, host_state_i = 0, host_clr_idx_i = 0;
  logic [9:0] host_vid_i = 0, host_pid_i = 0, eoi_vid_i = 0;
  logic       ack_i = 0, eoi_i = 0;
  logic       ack_vld_o, pdeact_o, wr_err_o, eoi_err_o;
  logic [9:0] ack_vid_o, pdeact_pid_o;
  logic [7:0] lr_state_o;
  logic [3:0] lr_hw_o;

  int n_run = 0, n_fail = 0;
  logic [9:0] ack_q[$];
  logic [9:0] pd_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  virq_lr_unit dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected items as results appear
  always @(negedge clk_i) begin
    if (rst_ni && ack_vld_o) begin
      if (ack_q.size() == 0) chk(0, "R4 unexpected ack", ack_vid_o, 0);
      else begin
        logic [9:0] e;
        e = ack_q.pop_front();
        chk(ack_vid_o == e, "R4/R5 ack id", ack_vid_o, e);
      end
    end
    if (rst_ni && pdeact_o) begin
      if (pd_q.size() == 0) chk(0, "R7/R8 unexpected pdeact", pdeact_pid_o, 0);
      else begin
        logic [9:0] e;
        e = pd_q.pop_front();
        chk(pdeact_pid_o == e, "R7 pdeact pid", pdeact_pid_o, e);
      end
    end
  end

  task automatic wr(input int idx, input int vid, input int pid, input bit hw, input int st);
    @(negedge clk_i);
    host_wr_i = 1; host_idx_i = 2'(idx); host_vid_i = 10'(vid);
    host_pid_i = 10'(pid); host_hw_i = hw; host_state_i = 2'(st);
    @(negedge clk_i);
    host_wr_i = 0;
  endtask

  task automatic clr(input int idx);
    @(negedge clk_i);
    host_clr_i = 1; host_clr_idx_i = 2'(idx);
    @(negedge clk_i);
    host_clr_i = 0;
  endtask

  task automatic ack(input int exp);
    ack_q.push_back(10'(exp));
    @(negedge clk_i);
    ack_i = 1;
    @(negedge clk_i);
    ack_i = 0;
  endtask

  task automatic eoi(input int vid, input bit fwd, input int pid);
    if (fwd) pd_q.push_back(10'(pid));
    @(negedge clk_i);
    eoi_i = 1; eoi_vid_i = 10'(vid);
    @(negedge clk_i);
    eoi_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(lr_state_o == 8'h00 && lr_hw_o == 0, "R1 reset entries", lr_state_o, 0);
    chk(!ack_vld_o && !pdeact_o && !wr_err_o && !eoi_err_o, "R1 reset outputs",
        {ack_vld_o, pdeact_o, wr_err_o, eoi_err_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    wr(0, 40, 0, 0, 1);
    wr(1, 41, 300, 1, 1);
    wr(2, 42, 0, 0, 3);
    chk(lr_state_o == 8'h35, "R2 state after writes", lr_state_o, 8'h35);
    chk(lr_hw_o == 4'b0010, "R2 hw flags", lr_hw_o, 4'b0010);

    wr(3, 77, 5, 1, 3);
    chk(wr_err_o == 1, "R3 error pulse", wr_err_o, 1);
    chk(lr_state_o == 8'h35 && lr_hw_o == 4'b0010, "R3 entry unchanged", lr_state_o, 8'h35);
    @(negedge clk_i);
    chk(wr_err_o == 0, "R3 pulse one cycle", wr_err_o, 0);

    ack(40);
    chk(lr_state_o == 8'h36, "R4 pending to active", lr_state_o, 8'h36);
    ack(41);
    ack(42);
    chk(lr_state_o == 8'h2A, "R4 P+A to active", lr_state_o, 8'h2A);
    ack(1023);
    chk(lr_state_o == 8'h2A, "R5 spurious no change", lr_state_o, 8'h2A);

    eoi(999, 0, 0);
    chk(eoi_err_o == 1, "R9 error set", eoi_err_o, 1);
    chk(lr_state_o == 8'h2A, "R9 no change", lr_state_o, 8'h2A);

    eoi(40, 0, 0);
    chk(lr_state_o == 8'h28, "R6 active to inactive", lr_state_o, 8'h28);

    eoi(41, 1, 300);
    chk(pdeact_o == 1, "R7 pdeact raised", pdeact_o, 1);
    chk(lr_state_o == 8'h28, "R7 stays active", lr_state_o, 8'h28);
    @(negedge clk_i);
    chk(pdeact_o == 0, "R7 pulse one cycle", pdeact_o, 0);

    eoi(41, 0, 0);
    chk(pdeact_o == 0, "R8 no second request", pdeact_o, 0);
    chk(lr_state_o == 8'h28, "R8 state held", lr_state_o, 8'h28);
    chk(eoi_err_o == 1, "R9 error sticky", eoi_err_o, 1);

    wr(0, 60, 0, 0, 3);
    eoi(60, 0, 0);
    chk(lr_state_o == 8'h29, "R6 P+A to pending", lr_state_o, 8'h29);
    ack(60);
    chk(lr_state_o == 8'h2A, "R4 reacquire", lr_state_o, 8'h2A);
    eoi(60, 0, 0);

    clr(1);
    chk(lr_state_o == 8'h20 && lr_hw_o == 4'b0000, "R10 clear", {lr_state_o, lr_hw_o}, 12'h200);

    @(negedge clk_i);
    host_clr_i = 1; host_clr_idx_i = 2'd3;
    host_wr_i = 1; host_idx_i = 2'd3; host_vid_i = 10'd90;
    host_pid_i = 10'd9; host_hw_i = 1; host_state_i = 2'b01;
    @(negedge clk_i);
    host_clr_i = 0; host_wr_i = 0;
    chk(lr_state_o == 8'h20 && lr_hw_o == 4'b0000, "R11 clear wins", {lr_state_o, lr_hw_o}, 12'h200);

    wr(2, 50, 0, 0, 2);
    wr(3, 50, 0, 0, 2);
    chk(lr_state_o == 8'hA0, "R2 two active", lr_state_o, 8'hA0);
    eoi(50, 0, 0);
    chk(lr_state_o == 8'h80, "R12 lowest index first", lr_state_o, 8'h80);
    eoi(50, 0, 0);
    chk(lr_state_o == 8'h00, "R12 second match", lr_state_o, 8'h00);

    repeat (3) @(negedge clk_i);
    chk(ack_q.size() == 0, "R4 all acks seen", ack_q.size(), 0);
    chk(pd_q.size() == 0, "R7 all requests seen", pd_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule